// File: doc/BRIEF.md
# Six-Pin External Interrupt Request Detector

This block watches a set of asynchronous external interrupt pins and turns each pin's activity into a request line for the interrupt controller. Each pin first passes through a two-stage synchroniser. A previous-sample register then detects an edge by comparing the current synchronised level with the one before it. On a detected edge the block sets a sticky request flag that software removes through a clear port.

A byte-wide mode register controls how each pin is sensed. Every pin has a polarity bit that selects rising or falling edges. Pin 0 also has a level-enable bit. When that bit is set, pin 0's request output follows the synchronised input level and its polarity bit is ignored. Only the two pin-0 bits can be read back, so software cannot safely do a read-modify-write on the whole register. When pin 0 goes from level mode back to edge mode, any flag it latched in the meantime can be discarded through the clear port.

The CPU side uses plain strobes with no handshake. A register write takes one cycle. A clear takes one cycle and names the pin by its identifier. The request outputs are plain level signals.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset, every request output is 0, the mode register is 0 (all pins in rising-edge mode, pin 0 in edge mode), and `cfg_rdata` is 0.
- R2: Mode register layout: bit 0 is pin 0's level enable, bit p+1 is pin p's polarity (0 = rising, 1 = falling), and bit 7 is reserved. A write with `cfg_we` high is applied at the next rising clock edge.
- R3: `cfg_rdata` returns mode bits 1 and 0 in the same positions, and every other bit reads 0.
- R4: With polarity 0, a low-to-high change of a pin sets its request flag. If the pin changes before rising edge k, the request is visible after rising edge k+2.
- R5: With polarity 1, a high-to-low change sets the flag with the same latency, and a rising change does not.
- R6: A set flag stays set until a cycle with `clr_en` high and `clr_id` equal to the pin number (0 to 5). That flag is 0 after the next edge. Identifiers 6 and 7 clear nothing.
- R7: If a qualifying edge and a matching clear hit the same cycle, the flag ends up set.
- R8: With level enable at 1, `irq_req[0]` equals the pin-0 level delayed by two rising edges. It is not latched and does not depend on pin 0's polarity bit.
- R9: Changing a polarity bit while a pin is steady raises no request.
- R10: Pin 0's edge flag keeps latching edges while level mode is on. After a switch back to edge mode, that stale flag shows on `irq_req[0]` until a clear with identifier 0 removes it.
- R11: Each pin's detection, flag and clear act independently of the other pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 6 | Asynchronous external interrupt pins |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write data |
| cfg_rdata | output | 8 | Mode register readback (bits 1:0 only) |
| clr_en | input | 1 | Clear strobe |
| clr_id | input | 3 | Identifier of the flag to clear |
| irq_req | output | 6 | Per-pin request outputs |

## Verification
Assertions inside the edge unit check on every cycle that a flag never sets without a detected edge, that it holds while no clear arrives, that a clear with no edge drops it, and that an edge always leaves it set. The mode register's one-cycle write latency is also checked on every cycle. Only the bench scenarios can show the end-to-end pin-to-request latency, that a polarity change on a steady pin raises no request, that pin 0's level mode passes through with its polarity ignored, and that a stale pin-0 flag survives the switch back to edge mode until it is cleared.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned NUM_PINS   = 6;
  localparam int unsigned MODE_W     = 8;
  localparam int unsigned ID_W       = 3;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned LVL_BIT    = 0;

  // polarity field position of a pin
  function automatic int unsigned pol_pos(input int unsigned pin);
    return pin + 1;
  endfunction

  // bits of the mode register that software may read back
  function automatic logic [MODE_W-1:0] read_mask();
    logic [MODE_W-1:0] m;
    m = '0;
    m[LVL_BIT]    = 1'b1;
    m[pol_pos(0)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= async_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/ext_irq_modereg.sv
module ext_irq_modereg
  import ext_irq_pkg::*;
#(
  parameter int unsigned W = MODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mode,
  output logic [W-1:0] rdata
);
  localparam logic [W-1:0] RMASK = W'(read_mask());

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= '0;
    else if (we) mode <= wdata;
  end

  assign rdata = mode & RMASK;

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mode == $past(wdata)));
  assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mode));
endmodule

// File: rtl/ext_irq_edge.sv
module ext_irq_edge #(
  parameter bit HAS_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  input  logic pol_fall,
  input  logic lvl_en,
  input  logic clr_hit,
  output logic req_o
);
  logic prev_q;
  logic flag_q;
  logic hit;

  // previous sample follows the raw synchronised level, whatever the polarity
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else prev_q <= smp;
  end

  assign hit = pol_fall ? (prev_q & ~smp) : (smp & ~prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
    else if (clr_hit) flag_q <= 1'b0;
  end

  if (HAS_LEVEL) begin : g_level
    assign req_o = lvl_en ? smp : flag_q;
  end else begin : g_edge
    logic unused_lvl;
    assign unused_lvl = lvl_en;
    assign req_o = flag_q;
  end

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_hit) |=> flag_q);
  assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !hit) |=> !flag_q);
  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  assert_no_set_without_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !hit) |=> !flag_q);
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int unsigned PINS  = NUM_PINS,
  parameter int unsigned SYNC  = SYNC_DEPTH,
  localparam int unsigned MW   = PINS + 2,
  localparam int unsigned IW   = $clog2(PINS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PINS-1:0] pin_i,
  input  logic          cfg_we,
  input  logic [MW-1:0] cfg_wdata,
  output logic [MW-1:0] cfg_rdata,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_id,
  output logic [PINS-1:0] irq_req
);
  logic [PINS-1:0] smp;
  logic [MW-1:0]   mode;

  ext_irq_sync #(.WIDTH(PINS), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(smp)
  );

  ext_irq_modereg #(.W(MW)) u_mode (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .mode(mode), .rdata(cfg_rdata)
  );

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic clr_hit;
    assign clr_hit = clr_en && (clr_id == IW'(p));
    ext_irq_edge #(.HAS_LEVEL(p == 0)) u_edge (
      .clk(clk), .rst_n(rst_n), .smp(smp[p]),
      .pol_fall(mode[pol_pos(p)]), .lvl_en(mode[LVL_BIT]),
      .clr_hit(clr_hit), .req_o(irq_req[p])
    );
  end
endmodule

// File: tb/ext_irq_detect_tb.sv
module ext_irq_detect_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic [5:0] pin_i = '0;
  logic cfg_we = 0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic clr_en = 0;
  logic [2:0] clr_id = '0;
  logic [5:0] irq_req;

  int vectors = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ext_irq_detect u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .clr_en(clr_en),
    .clr_id(clr_id), .irq_req(irq_req)
  );

  // behavioural reference model
  int m_s1[6], m_s2[6], m_prev[6], m_flag[6];
  int m_mode[8];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0; m_flag[i] = 0;
      end
      for (int b = 0; b < 8; b++) m_mode[b] = 0;
    end else begin
      for (int i = 0; i < 6; i++) begin
        int rise, fall, edge_seen;
        rise = (m_s2[i] == 1 && m_prev[i] == 0);
        fall = (m_s2[i] == 0 && m_prev[i] == 1);
        edge_seen = m_mode[i+1] ? fall : rise;
        if (edge_seen) m_flag[i] = 1;
        else if (clr_en && clr_id == i) m_flag[i] = 0;
        m_prev[i] = m_s2[i];
        m_s2[i] = m_s1[i];
        m_s1[i] = pin_i[i];
      end
      if (cfg_we) for (int b = 0; b < 8; b++) m_mode[b] = cfg_wdata[b];
    end
  end

  function automatic logic [5:0] model_req();
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = m_flag[i][0];
    if (m_mode[0] == 1) r[0] = m_s2[0][0];
    return r;
  endfunction

  // compare on every clock (R11: all pins tracked independently)
  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] erd;
      erd = {6'b0, m_mode[1][0], m_mode[0][0]};
      vectors++;
      if (irq_req !== model_req() || cfg_rdata !== erd) begin
        errors++;
        $display("FAIL R11 per-cycle: irq_req=%b rdata=%h expected irq_req=%b rdata=%h",
                 irq_req, cfg_rdata, model_req(), erd);
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [7:0] v);
    cfg_we = 1; cfg_wdata = v;
    cyc(1);
    cfg_we = 0;
  endtask

  task automatic clr(input logic [2:0] id);
    clr_en = 1; clr_id = id;
    cyc(1);
    clr_en = 0;
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        check("R1 reset req", {2'b0, irq_req}, 8'h00);
        check("R1 reset rdata", cfg_rdata, 8'h00);

        // R2 / R3 write and readback
        wr_mode(8'hFF);
        check("R3 readback mask", cfg_rdata, 8'h03);
        wr_mode(8'h00);
        check("R2 write zero", cfg_rdata, 8'h00);

        // R4 rising edge on pin 1
        pin_i[1] = 1;
        cyc(2);
        check("R4 not yet", {7'b0, irq_req[1]}, 8'h00);
        cyc(1);
        check("R4 rising sets", {7'b0, irq_req[1]}, 8'h01);

        // R6 sticky and clear
        pin_i[1] = 0;
        cyc(5);
        check("R6 sticky", {7'b0, irq_req[1]}, 8'h01);
        clr(3'd7);
        check("R6 id7 ignored", {2'b0, irq_req}, 8'h02);
        clr(3'd6);
        check("R6 id6 ignored", {2'b0, irq_req}, 8'h02);
        clr(3'd1);
        check("R6 cleared", {7'b0, irq_req[1]}, 8'h00);

        // R5 falling on pin 3 (polarity bit 4)
        wr_mode(8'h10);
        pin_i[3] = 1;
        cyc(5);
        check("R5 rising ignored", {7'b0, irq_req[3]}, 8'h00);
        pin_i[3] = 0;
        cyc(3);
        check("R5 falling sets", {7'b0, irq_req[3]}, 8'h01);
        clr(3'd3);
        wr_mode(8'h00);

        // R9 polarity change on steady pin 2
        pin_i[2] = 1;
        cyc(4);
        clr(3'd2);
        wr_mode(8'h08);
        cyc(4);
        wr_mode(8'h00);
        cyc(4);
        check("R9 no false edge", {2'b0, irq_req}, 8'h00);

        // R7 edge and clear in the same cycle on pin 4
        pin_i[4] = 1;
        cyc(3);
        pin_i[4] = 0;
        cyc(4);
        check("R7 pre flag", {7'b0, irq_req[4]}, 8'h01);
        pin_i[4] = 1;
        cyc(2);
        clr(3'd4);
        check("R7 edge wins", {7'b0, irq_req[4]}, 8'h01);
        clr(3'd4);
        pin_i[4] = 0;
        cyc(3);

        // R8 level mode on pin 0
        wr_mode(8'h03);
        pin_i[0] = 1;
        cyc(1);
        check("R8 level not yet", {7'b0, irq_req[0]}, 8'h00);
        cyc(1);
        check("R8 level high", {7'b0, irq_req[0]}, 8'h01);
        pin_i[0] = 0;
        cyc(2);
        check("R8 level low", {7'b0, irq_req[0]}, 8'h00);

        // R10 stale flag across mode switch (polarity 0 in level mode)
        wr_mode(8'h01);
        pin_i[0] = 1;
        cyc(4);
        pin_i[0] = 0;
        cyc(4);
        check("R10 level low", {7'b0, irq_req[0]}, 8'h00);
        wr_mode(8'h00);
        check("R10 stale visible", {7'b0, irq_req[0]}, 8'h01);
        clr(3'd0);
        check("R10 stale cleared", {7'b0, irq_req[0]}, 8'h00);

        // R11 independence
        pin_i[5] = 1;
        cyc(3);
        check("R11 only pin5", {2'b0, irq_req}, 8'h20);
        clr(3'd5);
        check("R11 all clear", {2'b0, irq_req}, 8'h00);
        cyc(2);
      end
      begin
        while (wd < 20000) begin
          @(posedge clk);
          wd++;
        end
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule